// File: doc/BRIEF.md
# DMA Channel Transfer Count Control

This block holds the per-channel byte count and the upper half of the next-descriptor pointer for a chained DMA engine. When the descriptor fetcher reads a chain descriptor, it pulses a load strobe together with the descriptor's transfer-count field. The block keeps that count, limited to 16 MiB, in a 25-bit counter. As the destination side acknowledges write beats, the block lowers the count by the number of bytes in each beat. Software reads the remaining count as a read-only 32-bit word.

When the count reaches zero, either straight from a load or after a decrement, the block emits a one-cycle completion pulse. If the interrupt enable is high, it also sets a sticky interrupt-pending flag, which software clears with a write-one-to-clear strobe. A loaded count of zero is legal. It completes at once, and the bus-request output never rises for it.

The block also holds the channel Active state. A load taken while the Start control bit is set turns Active on. The completion pulse turns it off. The software-writable next-descriptor upper address accepts writes only while both Start and Active are clear.

Top module: `dma_xfer_count_ctl`

## Requirements
- R1: After reset, the count readback, the pointer, Active, the request output, done and the interrupt flag all read zero.
- R2: A load takes the smaller of the descriptor count and 16 MiB (0x0100_0000), with no error indication. The readback shows count bits 23:0 in bits 23:0 and zeros in bits 31:24, so an exact 16 MiB count reads back as zero.
- R3: A load with Start high sets Active on that clock edge. A load with Start low leaves Active unchanged.
- R4: A beat acknowledgement taken while Active is set and the count is nonzero lowers the count by its byte value (1 to 8). The result stops at zero and never wraps. At any other time a beat leaves the count unchanged.
- R5: `done` is high for exactly the one cycle after the count becomes zero, whether through a load or through a decrement.
- R6: Active clears at the first clock edge on which `done` is high, unless a started load arrives on that same edge.
- R7: `req_cycles` is high exactly when Active is set and the remaining count is nonzero. A zero-count descriptor therefore never raises it.
- R8: `irq_pend` sets when the count reaches zero while `irq_en` is high. It stays set until `irq_clr` is pulsed. A set and a clear on the same edge leave it set.
- R9: A pointer write is accepted only when Start and Active are both clear. Otherwise the write is ignored and the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| desc_load | input | 1 | Descriptor count field valid this cycle |
| desc_count | input | 32 | Transfer-count field from the descriptor |
| chan_start | input | 1 | Start control bit of the channel |
| beat_ack | input | 1 | Destination write beat acknowledged |
| beat_bytes | input | 4 | Bytes in the acknowledged beat (1 to 8) |
| irq_en | input | 1 | Completion interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear strobe for the pending flag |
| ptr_wr | input | 1 | Software write strobe for the pointer |
| ptr_wdata | input | 32 | Software write data for the pointer |
| count_rd | output | 32 | Remaining-count readback, bits 31:24 zero |
| ptr_rd | output | 32 | Next-descriptor upper-address readback |
| chan_active | output | 1 | Channel Active status |
| req_cycles | output | 1 | Permission to issue bus cycles |
| done | output | 1 | One-cycle completion pulse |
| irq_pend | output | 1 | Sticky completion interrupt pending |

## Verification
The bench builds the block with its default parameters: a 24-bit count field, a 32-bit register width and 4-bit beat sizes. These are the sizes at which the 16 MiB clamp and the 24-bit readback truncation actually differ from the raw descriptor value. A beat taken from an exact 16 MiB count crosses the full-scale boundary, which brings both the readback of zero at 16 MiB and the borrow into bit 23 within reach. An 8-byte beat against a small remainder exercises the stop at zero.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } chan_st_e;

endpackage

// File: rtl/dxc_count_unit.sv
module dxc_count_unit #(
  parameter int CNT_W  = 24,
  parameter int REG_W  = 32,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [REG_W-1:0]  load_val_i,
  input  logic              take_i,
  input  logic [BEAT_W-1:0] take_bytes_i,
  output logic [CNT_W:0]    cnt_o,
  output logic              zero_evt_o
);

  localparam int              FULL_W = CNT_W + 1;
  localparam logic [REG_W-1:0] LIMIT  = REG_W'(1) << CNT_W;

  logic [FULL_W-1:0] cnt_q;
  logic [FULL_W-1:0] cnt_d;
  logic              cnt_en;
  logic [FULL_W-1:0] clamped;
  logic [FULL_W-1:0] bytes_ext;

  // Oversized descriptor counts are limited without any error flag.
  assign clamped   = (load_val_i > LIMIT) ? LIMIT[FULL_W-1:0] : load_val_i[FULL_W-1:0];
  assign bytes_ext = FULL_W'(take_bytes_i);

  always_comb begin
    cnt_en     = 1'b0;
    cnt_d      = cnt_q;
    zero_evt_o = 1'b0;
    if (load_i) begin
      cnt_en     = 1'b1;
      cnt_d      = clamped;
      zero_evt_o = (clamped == '0);
    end else if (take_i) begin
      cnt_en = 1'b1;
      if (bytes_ext >= cnt_q) begin
        cnt_d      = '0;
        zero_evt_o = 1'b1;
      end else begin
        cnt_d = cnt_q - bytes_ext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R2: a load never leaves more than the full-scale count
  p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q <= LIMIT[FULL_W-1:0]));

  // R4: an oversized beat stops the count at zero
  p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !load_i && (bytes_ext >= cnt_q)) |=> (cnt_q == '0));

  // R4: with no load and no accepted beat the count holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !take_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dxc_chan_ctrl.sv
module dxc_chan_ctrl
  import dxc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic start_i,
  input  logic beat_i,
  input  logic zero_evt_i,
  input  logic cnt_nz_i,
  input  logic irq_en_i,
  input  logic irq_clr_i,
  output logic take_o,
  output logic active_o,
  output logic req_o,
  output logic done_o,
  output logic irq_o
);

  chan_st_e st_q, st_d;
  logic     done_q, done_d;
  logic     irq_q, irq_d;

  always_comb begin
    st_d = st_q;
    if (load_i && start_i) begin
      st_d = CH_RUN;
    end else if (done_q) begin
      st_d = CH_IDLE;
    end
  end

  always_comb begin
    done_d = zero_evt_i;
    irq_d  = (zero_evt_i && irq_en_i) || (irq_q && !irq_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  assign active_o = (st_q == CH_RUN);
  assign take_o   = beat_i && active_o && cnt_nz_i;
  assign req_o    = active_o && cnt_nz_i;
  assign done_o   = done_q;
  assign irq_o    = irq_q;

  // R5: completion is a single-cycle pulse unless a new load re-triggers it
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> !done_o);

  // R6: completion drops Active on the next edge
  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !(load_i && start_i)) |=> !active_o);

  // R3: a started load makes the channel active
  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && start_i) |=> active_o);

  // R8: the pending flag survives until cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  // R8: an enabled completion always raises the flag
  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt_i && irq_en_i) |=> irq_o);

endmodule

// File: rtl/dxc_ptr_reg.sv
module dxc_ptr_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             lock_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);

  logic [REG_W-1:0] q_r;
  logic             wr_en;

  assign wr_en = wr_i && !lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (wr_en) begin
      q_r <= wdata_i;
    end
  end

  assign q_o = q_r;

  // R9: writes while locked leave the pointer untouched
  p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && lock_i) |=> $stable(q_o));

  // R9: unlocked writes land
  p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !lock_i) |=> (q_o == $past(wdata_i)));

endmodule

// File: rtl/dma_xfer_count_ctl.sv
module dma_xfer_count_ctl #(
  parameter int CNT_W  = 24,
  parameter int REG_W  = 32,
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_load,
  input  logic [REG_W-1:0]  desc_count,
  input  logic              chan_start,
  input  logic              beat_ack,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              irq_en,
  input  logic              irq_clr,
  input  logic              ptr_wr,
  input  logic [REG_W-1:0]  ptr_wdata,
  output logic [REG_W-1:0]  count_rd,
  output logic [REG_W-1:0]  ptr_rd,
  output logic              chan_active,
  output logic              req_cycles,
  output logic              done,
  output logic              irq_pend
);

  localparam int PAD_W = REG_W - CNT_W;

  logic [CNT_W:0] cnt;
  logic           zero_evt;
  logic           take;
  logic           cnt_nz;

  assign cnt_nz = (cnt != '0);

  dxc_count_unit #(
    .CNT_W (CNT_W),
    .REG_W (REG_W),
    .BEAT_W(BEAT_W)
  ) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (desc_load),
    .load_val_i  (desc_count),
    .take_i      (take),
    .take_bytes_i(beat_bytes),
    .cnt_o       (cnt),
    .zero_evt_o  (zero_evt)
  );

  dxc_chan_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (desc_load),
    .start_i   (chan_start),
    .beat_i    (beat_ack),
    .zero_evt_i(zero_evt),
    .cnt_nz_i  (cnt_nz),
    .irq_en_i  (irq_en),
    .irq_clr_i (irq_clr),
    .take_o    (take),
    .active_o  (chan_active),
    .req_o     (req_cycles),
    .done_o    (done),
    .irq_o     (irq_pend)
  );

  dxc_ptr_reg #(
    .REG_W(REG_W)
  ) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (ptr_wr),
    .lock_i (chan_start || chan_active),
    .wdata_i(ptr_wdata),
    .q_o    (ptr_rd)
  );

  // Reserved upper bits read as zero; the full-scale bit is not visible.
  assign count_rd = {{PAD_W{1'b0}}, cnt[CNT_W-1:0]};

  // R7: an empty count never requests bus cycles
  p_zero_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !req_cycles);

  // R5: done only follows a count that is now zero
  p_done_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count_rd == '0) || desc_load || $past(desc_load));

endmodule

// File: tb/dma_xfer_count_ctl_test.sv
module dma_xfer_count_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        desc_load;
  logic [31:0] desc_count;
  logic        chan_start;
  logic        beat_ack;
  logic [3:0]  beat_bytes;
  logic        irq_en;
  logic        irq_clr;
  logic        ptr_wr;
  logic [31:0] ptr_wdata;
  logic [31:0] count_rd;
  logic [31:0] ptr_rd;
  logic        chan_active;
  logic        req_cycles;
  logic        done;
  logic        irq_pend;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dma_xfer_count_ctl uut (
    .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_count(desc_count),
    .chan_start(chan_start), .beat_ack(beat_ack), .beat_bytes(beat_bytes),
    .irq_en(irq_en), .irq_clr(irq_clr), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .count_rd(count_rd), .ptr_rd(ptr_rd), .chan_active(chan_active),
    .req_cycles(req_cycles), .done(done), .irq_pend(irq_pend)
  );

  typedef struct packed {
    logic        ld;
    logic [31:0] cnt;
    logic        st;
    logic        bt;
    logic [3:0]  by;
    logic        ie;
    logic        ic;
    logic        pw;
    logic [31:0] pd;
    logic [31:0] e_cnt;
    logic        e_act;
    logic        e_req;
    logic        e_done;
    logic        e_irq;
    logic [31:0] e_ptr;
  } vec_t;

  localparam logic [31:0] PA = 32'hA5A5_0001;
  localparam logic [31:0] PB = 32'h1234_5678;

  localparam vec_t VEC [0:17] = '{
    '{1'b0, 32'd0,         1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, PA,            32'd0,         1'b0, 1'b0, 1'b0, 1'b0, PA},
    '{1'b1, 32'd20,        1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 32'd0,         32'd20,        1'b1, 1'b1, 1'b0, 1'b0, PA},
    '{1'b0, 32'd0,         1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 32'hFFFF_0000, 32'd20,        1'b1, 1'b1, 1'b0, 1'b0, PA},
    '{1'b0, 32'd0,         1'b1, 1'b1, 4'd8, 1'b1, 1'b0, 1'b0, 32'd0,         32'd12,        1'b1, 1'b1, 1'b0, 1'b0, PA},
    '{1'b0, 32'd0,         1'b1, 1'b1, 4'd8, 1'b1, 1'b0, 1'b0, 32'd0,         32'd4,         1'b1, 1'b1, 1'b0, 1'b0, PA},
    '{1'b0, 32'd0,         1'b0, 1'b1, 4'd3, 1'b1, 1'b0, 1'b1, 32'hFFFF_0000, 32'd1,         1'b1, 1'b1, 1'b0, 1'b0, PA},
    '{1'b0, 32'd0,         1'b0, 1'b1, 4'd8, 1'b1, 1'b0, 1'b0, 32'd0,         32'd0,         1'b1, 1'b0, 1'b1, 1'b1, PA},
    '{1'b0, 32'd0,         1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 32'd0,         32'd0,         1'b0, 1'b0, 1'b0, 1'b1, PA},
    '{1'b0, 32'd0,         1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 32'd0,         32'd0,         1'b0, 1'b0, 1'b0, 1'b0, PA},
    '{1'b0, 32'd0,         1'b0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, 32'd0,         32'd0,         1'b0, 1'b0, 1'b0, 1'b0, PA},
    '{1'b1, 32'h0300_0000, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 32'd0,         32'd0,         1'b1, 1'b1, 1'b0, 1'b0, PA},
    '{1'b0, 32'd0,         1'b1, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 32'd0,         32'h00FF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, PA},
    '{1'b1, 32'd0,         1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 32'd0,         32'd0,         1'b1, 1'b0, 1'b1, 1'b1, PA},
    '{1'b0, 32'd0,         1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 32'd0,         32'd0,         1'b0, 1'b0, 1'b0, 1'b1, PA},
    '{1'b0, 32'd0,         1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 32'd0,         32'd0,         1'b0, 1'b0, 1'b0, 1'b0, PA},
    '{1'b1, 32'h00FF_FFFF, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 32'd0,         32'h00FF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, PA},
    '{1'b0, 32'd0,         1'b0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b1, PB,            32'h00FF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, PB},
    '{1'b1, 32'd0,         1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 32'd0,         32'd0,         1'b1, 1'b0, 1'b1, 1'b1, PB}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    desc_load = 1'b0; desc_count = '0; chan_start = 1'b0; beat_ack = 1'b0;
    beat_bytes = '0; irq_en = 1'b0; irq_clr = 1'b0; ptr_wr = 1'b0; ptr_wdata = '0;
  endtask

  task automatic check_all(input string ctx, input logic [31:0] e_cnt, input logic e_act,
                           input logic e_req, input logic e_done, input logic e_irq,
                           input logic [31:0] e_ptr);
    chk({ctx, " R2/R4 count"}, count_rd, e_cnt);
    chk({ctx, " R3/R6 active"}, {31'd0, chan_active}, {31'd0, e_act});
    chk({ctx, " R7 req"}, {31'd0, req_cycles}, {31'd0, e_req});
    chk({ctx, " R5 done"}, {31'd0, done}, {31'd0, e_done});
    chk({ctx, " R8 irq"}, {31'd0, irq_pend}, {31'd0, e_irq});
    chk({ctx, " R9 ptr"}, ptr_rd, e_ptr);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_all("R1 reset", 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      desc_load  = VEC[i].ld;
      desc_count = VEC[i].cnt;
      chan_start = VEC[i].st;
      beat_ack   = VEC[i].bt;
      beat_bytes = VEC[i].by;
      irq_en     = VEC[i].ie;
      irq_clr    = VEC[i].ic;
      ptr_wr     = VEC[i].pw;
      ptr_wdata  = VEC[i].pd;
      @(posedge clk);
      #1;
      check_all($sformatf("vec%0d", i), VEC[i].e_cnt, VEC[i].e_act, VEC[i].e_req,
                VEC[i].e_done, VEC[i].e_irq, VEC[i].e_ptr);
    end

    // R2: exactly 16 MiB reads as zero yet requests cycles; one 8-byte beat borrows
    @(negedge clk);
    idle_inputs();
    desc_load = 1'b1; desc_count = 32'h0100_0000; chan_start = 1'b1;
    @(posedge clk); #1;
    chk("R2 full-scale readback", count_rd, 32'd0);
    chk("R7 full-scale req", {31'd0, req_cycles}, 32'd1);
    @(negedge clk);
    desc_load = 1'b0; beat_ack = 1'b1; beat_bytes = 4'd8;
    @(posedge clk); #1;
    chk("R4 borrow from full scale", count_rd, 32'h00FF_FFF8);
    chk("R5 no done mid-transfer", {31'd0, done}, 32'd0);

    // R1: reset while running clears everything, including the pointer
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check_all("R1 mid-run reset", 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: write lands once start drops and channel idle after reset
    @(negedge clk);
    ptr_wr = 1'b1; ptr_wdata = 32'hCAFE_0042;
    @(posedge clk); #1;
    chk("R9 idle write", ptr_rd, 32'hCAFE_0042);

    @(negedge clk);
    idle_inputs();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule